// File: doc/BRIEF.md
# Adaptive Delta Modulation Encoder

This block turns a stream of 8-bit signed PCM samples into a one-bit adaptive delta modulation stream, producing exactly one output bit per sample period. It holds a signed step value, a signed running prediction of the input, and a short history of the bits it has already sent. A matching decoder that replays the same adaptation on the received bits rebuilds the encoder's prediction exactly.

Each sample strobe performs one complete update in a single clock cycle. The step is first forced to its magnitude. It takes a negative sign when the newest history bit is zero. It is then nudged up or down by one according to the older history bit. The new step is added to the prediction. The input is compared against the updated prediction, and the result is shifted into the history and presented on the output. Between strobes every register holds its value.

Top module: `adm_encoder`

## Requirements
- R1: An active reset (rst_ni low) clears the step, the prediction and the history to zero, so adm_o reads 0; with that state, a first strobe on an input of 0 produces a 1.
- R2: While sample_en_i is low, the step, the prediction, the history and adm_o keep their values.
- R3: On a strobe, the step becomes its absolute value, negated if history bit 0 (newest decision) is 0, then incremented by 1 if history bit 1 (previous decision) is 1, else decremented by 1; its least significant bit therefore toggles on every strobe.
- R4: On a strobe, the prediction increases by the step computed in that same strobe; from reset with the output held at 1, the prediction runs -1, -1, 0, 2, 5, 9, 14, 20.
- R5: Step and prediction arithmetic wraps modulo 256 in two's complement with no saturation; from reset with a constant input of 127, the eighteenth prediction is -121.
- R6: On a strobe, the history shifts one place toward its MSB and the new decision enters at bit 0.
- R7: The decision is 1 only when the input, read as signed, is strictly greater than the updated prediction; equality gives 0.
- R8: adm_o is history bit 0. It changes at the clock edge that samples a strobe and holds until the next strobe.
- R9: A decoder that applies the same step and prediction update to the bits seen on adm_o reproduces the encoder's prediction after every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_en_i | input | 1 | One-cycle strobe that starts a sample period update |
| pcm_i | input | 8 | Signed two's-complement PCM sample, held stable for the whole period |
| adm_o | output | 1 | Registered delta modulation bit |

## Verification
The assertions assume that pcm_i is valid and stable in the cycle a strobe is sampled. They assume the comparison and the history update use that same value. They also assume the strobe carries no X once reset is released. The bench changes pcm_i and sample_en_i only on the falling edge, with one value per cycle. It sets the sample before or together with the strobe, so every sampled strobe sees a settled input. Strobe density is randomised to exercise the hold behaviour between sample periods.

// File: rtl/adm_pkg.sv
`timescale 1ns/1ps
package adm_pkg;
  localparam int unsigned ADM_DATA_W = 8;
  localparam int unsigned ADM_HIST_W = 8;

  typedef enum logic {
    NUDGE_DOWN = 1'b0,
    NUDGE_UP   = 1'b1
  } nudge_e;
endpackage

// File: rtl/adm_step_adapt.sv
`timescale 1ns/1ps
module adm_step_adapt
  import adm_pkg::*;
#(
  parameter int unsigned DATA_W = ADM_DATA_W
) (
  input  logic signed [DATA_W-1:0] step_i,
  input  logic                     newest_i,
  input  logic                     older_i,
  output logic signed [DATA_W-1:0] step_o
);
  localparam logic signed [DATA_W-1:0] UNIT = DATA_W'(1);

  logic signed [DATA_W-1:0] mag;
  logic signed [DATA_W-1:0] signed_step;
  nudge_e                   dir;

  always_comb begin
    // magnitude wraps: most negative value maps onto itself
    mag         = step_i[DATA_W-1] ? -step_i : step_i;
    signed_step = newest_i ? mag : -mag;
    dir         = older_i ? NUDGE_UP : NUDGE_DOWN;
    step_o      = (dir == NUDGE_UP) ? signed_step + UNIT : signed_step - UNIT;
  end
endmodule

// File: rtl/adm_predictor.sv
`timescale 1ns/1ps
module adm_predictor
  import adm_pkg::*;
#(
  parameter int unsigned DATA_W = ADM_DATA_W
) (
  input  logic signed [DATA_W-1:0] pred_i,
  input  logic signed [DATA_W-1:0] step_i,
  output logic signed [DATA_W-1:0] pred_o
);
  assign pred_o = pred_i + step_i;
endmodule

// File: rtl/adm_decide.sv
`timescale 1ns/1ps
module adm_decide
  import adm_pkg::*;
#(
  parameter int unsigned DATA_W = ADM_DATA_W
) (
  input  logic [DATA_W-1:0]        pcm_i,
  input  logic signed [DATA_W-1:0] pred_i,
  output logic                     bit_o
);
  logic signed [DATA_W-1:0] sample;

  assign sample = $signed(pcm_i);
  assign bit_o  = sample > pred_i;
endmodule

// File: rtl/adm_encoder.sv
`timescale 1ns/1ps
module adm_encoder
  import adm_pkg::*;
#(
  parameter int unsigned DATA_W = ADM_DATA_W,
  parameter int unsigned HIST_W = ADM_HIST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_en_i,
  input  logic [DATA_W-1:0] pcm_i,
  output logic              adm_o
);
  logic signed [DATA_W-1:0] step_q, step_d;
  logic signed [DATA_W-1:0] pred_q, pred_d;
  logic [HIST_W-1:0]        hist_q;
  logic                     decision;

  adm_step_adapt #(.DATA_W(DATA_W)) i_step (
    .step_i   (step_q),
    .newest_i (hist_q[0]),
    .older_i  (hist_q[1]),
    .step_o   (step_d)
  );

  adm_predictor #(.DATA_W(DATA_W)) i_pred (
    .pred_i (pred_q),
    .step_i (step_d),
    .pred_o (pred_d)
  );

  adm_decide #(.DATA_W(DATA_W)) i_decide (
    .pcm_i  (pcm_i),
    .pred_i (pred_d),
    .bit_o  (decision)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      pred_q <= '0;
      hist_q <= '0;
    end else if (sample_en_i) begin
      step_q <= step_d;
      pred_q <= pred_d;
      hist_q <= {hist_q[HIST_W-2:0], decision};
    end
  end

  assign adm_o = hist_q[0];
endmodule

// File: rtl/adm_encoder_chk.sv
`timescale 1ns/1ps
module adm_encoder_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned HIST_W = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     sample_en_i,
  input logic [DATA_W-1:0]        pcm_i,
  input logic                     adm_o,
  input logic signed [DATA_W-1:0] step_q,
  input logic signed [DATA_W-1:0] pred_q,
  input logic [HIST_W-1:0]        hist_q
);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_i |=> $stable(step_q) && $stable(pred_q) && $stable(hist_q) && $stable(adm_o));

  p_step_parity_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_en_i |=> step_q[0] != $past(step_q[0]));

  p_pred_update_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_en_i |=> pred_q == DATA_W'($past(pred_q) + step_q));

  p_hist_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_en_i |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]));

  p_decision_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_en_i |=> adm_o == ($signed($past(pcm_i)) > pred_q));
endmodule

bind adm_encoder adm_encoder_chk #(.DATA_W(DATA_W), .HIST_W(HIST_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sample_en_i (sample_en_i),
  .pcm_i       (pcm_i),
  .adm_o       (adm_o),
  .step_q      (step_q),
  .pred_q      (pred_q),
  .hist_q      (hist_q)
);

// File: tb/test_adm_encoder.sv
`timescale 1ns/1ps
module test_adm_encoder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sample_en_i = 1'b0;
  logic [7:0] pcm_i = '0;
  logic       adm_o;

  int checks = 0;
  int errors = 0;
  int e_step, e_pred, e_hist;
  int d_step, d_pred, d_hist;

  always #2.5 clk_i = ~clk_i;

  adm_encoder i_adm_encoder (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_en_i (sample_en_i),
    .pcm_i       (pcm_i),
    .adm_o       (adm_o)
  );

  function automatic int wrap8(int v);
    int r;
    r = v & 255;
    return (r >= 128) ? r - 256 : r;
  endfunction

  function automatic int adapt(int s, int h);
    int a;
    a = wrap8((s < 0) ? -s : s);
    if (h[0] == 1'b0) a = wrap8(-a);
    a = wrap8(a + (h[1] ? 1 : -1));
    return a;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    sample_en_i = 1'b0;
    pcm_i = '0;
    e_step = 0; e_pred = 0; e_hist = 0;
    d_step = 0; d_pred = 0; d_hist = 0;
    @(negedge clk_i);
    check("R1 adm_o in reset", int'(adm_o), 0);
    rst_ni = 1'b1;
  endtask

  // drive at falling edge, update models at the rising edge, sample 1 ns later
  task automatic tick(bit en, int pcm);
    bit b;
    @(negedge clk_i);
    sample_en_i = en;
    pcm_i = pcm[7:0];
    @(posedge clk_i);
    if (en) begin
      e_step = adapt(e_step, e_hist);
      e_pred = wrap8(e_pred + e_step);
      b = (pcm > e_pred);
      e_hist = ((e_hist << 1) | int'(b)) & 3;
    end
    #1;
    check("R6,R8 adm_o vs model", int'(adm_o), e_hist & 1);
    if (en) begin
      d_step = adapt(d_step, d_hist);
      d_pred = wrap8(d_pred + d_step);
      d_hist = ((d_hist << 1) | int'(adm_o)) & 3;
      check("R9 decoder reconstruction", d_pred, e_pred);
    end
  endtask

  initial begin
    int exp_pred [8] = '{-1, -1, 0, 2, 5, 9, 14, 20};
    int held;

    // R1: zero state, first decision on input 0 is 1
    do_reset();
    tick(1'b1, 0);
    check("R1 first bit after reset", int'(adm_o), 1);

    // R7: equality with prediction (-1) gives 0
    do_reset();
    tick(1'b1, -1);
    check("R7 equal input gives 0", int'(adm_o), 0);

    // R4 and R5: constant full-scale input
    do_reset();
    for (int n = 1; n <= 18; n++) begin
      tick(1'b1, 127);
      if (n <= 8) check("R4 prediction sequence", d_pred, exp_pred[n-1]);
      if (n == 18) check("R5 wrapped prediction", d_pred, -121);
    end
    check("R5 output after wrap", int'(adm_o), 1);

    // R2: no strobe, no change, then resume in step with model
    held = int'(adm_o);
    for (int k = 0; k < 6; k++) begin
      tick(1'b0, -100 + k * 40);
      check("R2 hold without strobe", int'(adm_o), held);
    end
    for (int k = 0; k < 10; k++) tick(1'b1, -60);

    // R3, R6: full ramp
    do_reset();
    for (int v = -128; v < 128; v++) tick(1'b1, v);
    for (int v = 127; v >= -128; v -= 3) tick(1'b1, v);

    // random input with random strobe density
    do_reset();
    for (int k = 0; k < 4000; k++) begin
      tick(($urandom % 4) != 0, int'($urandom % 256) - 128);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule